// File: doc/BRIEF.md
# Banked Register Decoder for a Multi-Channel Analog Output Card

This block sits between a 16-bit host I/O bus and the rest of an analog-output card. It decodes a 32-byte window of byte addresses. It holds two control words and a digital I/O output latch. It keeps three sticky interrupt flags and turns bus accesses into single-cycle strobes. Those strobes go to the converter channels, the sample FIFO and a synchronisation shift line. The converters, the FIFO storage and the interval timer are outside the block. The FIFO appears only as three level inputs and two strobes.

Bit 7 of the primary control word selects one of two write banks. In the second bank, the low offsets stop holding data. A write there clears one flag or drives the sync line instead. The first data offset is shared. With the second bank selected it feeds converter channel 0, and otherwise it pushes a word into the FIFO. Reading that same offset empties the FIFO. Every output is registered. A write takes effect in the cycle after the bus strobe, and read data is valid one cycle after the read strobe.

Top module: `aoc_regbank`

## Requirements
- R1: After reset, ctl_a_q, ctl_b_q, flag_q, dio_out and dio_oe are zero, all strobes are low, and the first bank is selected.
- R2: A write to offset 0x0a loads ctl_a_q with the bus data in either bank. ctl_a_q bit 7 set selects the second bank.
- R3: A read of offset 0x0a returns the status word: bit 6 fifo_half, bit 5 fifo_empty, bit 4 fifo_full, bit 3 INT2 flag, bit 2 INT1 flag, bit 1 terminal-count flag, bit 0 cal_sdo, with the upper bits zero.
- R4: Each flag sets one cycle after an enabled event and then stays set. The enables are in ctl_a_q: bit 14 for ext_evt1 and bit 12 for cnt_evt1 (both to INT1), bit 15 for ext_evt2 and bit 13 for cnt_evt2 (both to INT2), bit 11 for tc_evt. An event whose enable is clear sets nothing. flag_q is {INT2, INT1, TC}.
- R5: With the second bank selected, a write to 0x00 clears TC, a write to 0x02 clears INT1 and a write to 0x04 clears INT2. Each write clears only its own flag.
- R6: With the first bank selected, a write to 0x00 loads dio_out from data bits 7:0, and a write to 0x04 loads ctl_b_q from data bits 6:0. With the second bank selected, neither write changes them.
- R7: dio_oe[3:0] follows ctl_b_q bit 2, and dio_oe[7:4] follows ctl_b_q bit 3. A read of 0x00 returns the dio_pin_in values in bits 7:0.
- R8: A write to offset 0x0c+2x, for 1 <= x < NUM_CH, pulses dac_wr for one cycle in either bank. dac_chan is x and dac_data is bus data bits 11:0, passed on unchanged as a two's complement word.
- R9: A write to 0x0c pulses dac_wr for channel 0 when the second bank is selected. When the first bank is selected, it pulses fifo_wr instead, with the word on dac_data. dac_wr and fifo_wr are never high together.
- R10: A read of 0x0c pulses fifo_clr for one cycle.
- R11: With the second bank selected, a write to 0x06 loads sync_sdata from data bit 0, and a write to 0x07 pulses sync_strobe for one cycle.
- R12: A write to a data offset at or above channel NUM_CH produces no dac_wr or fifo_wr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after bus_rd |
| dio_pin_in | input | 8 | Digital I/O pin levels |
| dio_out | output | 8 | Digital I/O output latch |
| dio_oe | output | 8 | Per-pin output enables, nibble-wide |
| fifo_half | input | 1 | FIFO at least half full |
| fifo_empty | input | 1 | FIFO empty |
| fifo_full | input | 1 | FIFO full |
| cal_sdo | input | 1 | Calibration memory serial output |
| ext_evt1 | input | 1 | External interrupt event 1 |
| ext_evt2 | input | 1 | External interrupt event 2 |
| cnt_evt1 | input | 1 | Counter interrupt event 1 |
| cnt_evt2 | input | 1 | Counter interrupt event 2 |
| tc_evt | input | 1 | Transfer terminal-count event |
| ctl_a_q | output | 16 | Primary control word |
| ctl_b_q | output | 7 | Secondary control word |
| flag_q | output | 3 | Sticky flags {INT2, INT1, TC} |
| dac_wr | output | 1 | Converter channel write strobe |
| dac_chan | output | 4 | Channel number for dac_wr |
| dac_data | output | 12 | Converter or FIFO data word |
| fifo_wr | output | 1 | FIFO push strobe |
| fifo_clr | output | 1 | FIFO clear strobe |
| sync_sdata | output | 1 | Sync shift data latch |
| sync_strobe | output | 1 | Sync shift strobe |

## Verification
The bench targets the offsets whose meaning depends on the bank. If a write to 0x00 or 0x04 in the second bank also reached dio_out or ctl_b_q, the bench would see the earlier value overwritten. If a write to 0x0c ignored the bank bit, the scoreboard would receive a FIFO push where it expected a channel-0 converter write, or the reverse. Per-flag clears are checked with all three flags set, so a wrong clear wiring drops a neighbouring flag. Events are also applied with their enables clear, and a write is made to the first offset above the last channel, where a wrong range check shows up as an unexpected strobe.

// File: rtl/aoc_regbank_pkg.sv
package aoc_regbank_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int DIO_W  = 8;
  localparam int CTLB_W = 7;
  localparam int CH_W   = 4;
  localparam int DAC_W  = 12;
  localparam int NFLAG  = 3;

  localparam logic [ADDR_W-1:0] OFS_DIO    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_G2_I1  = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_CTLB   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_SYNC_D = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_SYNC_S = 5'h07;
  localparam logic [ADDR_W-1:0] OFS_CTLA   = 5'h0a;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 5'h0c;

  localparam int BIT_GRP2    = 7;
  localparam int BIT_TC_EN   = 11;
  localparam int BIT_CNT1_EN = 12;
  localparam int BIT_CNT2_EN = 13;
  localparam int BIT_EXT1_EN = 14;
  localparam int BIT_EXT2_EN = 15;
  localparam int BIT_OE_LO   = 2;
  localparam int BIT_OE_HI   = 3;

  localparam int FLG_TC = 0;
  localparam int FLG_I1 = 1;
  localparam int FLG_I2 = 2;

  typedef struct packed {
    logic             ld_dio;
    logic             ld_ctlb;
    logic             ld_ctla;
    logic             ld_sdat;
    logic             stb_sync;
    logic             wr_dac;
    logic             wr_fifo;
    logic [NFLAG-1:0] clr;
    logic [CH_W-1:0]  ch;
    logic             rd_dio;
    logic             rd_stat;
    logic             rd_fclr;
  } dec_t;
endpackage

// File: rtl/aoc_addr_decode.sv
module aoc_addr_decode
  import aoc_regbank_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic              grp2,
  output dec_t              dec
);
  localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(NUM_CH);

  logic [ADDR_W-1:0] rel;
  logic [CH_W-1:0]   ch_idx;
  logic              ch_ok;

  always_comb begin
    rel    = addr - OFS_DATA;
    ch_idx = CH_W'(rel >> 1);
    ch_ok  = (addr >= OFS_DATA) && !addr[0] && (ch_idx < CH_LIMIT);
  end

  always_comb begin
    dec    = '0;
    dec.ch = ch_idx;
    if (wr) begin
      if (addr == OFS_CTLA) dec.ld_ctla = 1'b1;
      if (grp2) begin
        case (addr)
          OFS_DIO:    dec.clr[FLG_TC] = 1'b1;
          OFS_G2_I1:  dec.clr[FLG_I1] = 1'b1;
          OFS_CTLB:   dec.clr[FLG_I2] = 1'b1;
          OFS_SYNC_D: dec.ld_sdat     = 1'b1;
          OFS_SYNC_S: dec.stb_sync    = 1'b1;
          default:    ;
        endcase
      end else begin
        if (addr == OFS_DIO)  dec.ld_dio  = 1'b1;
        if (addr == OFS_CTLB) dec.ld_ctlb = 1'b1;
      end
      if (ch_ok) begin
        if (ch_idx == '0 && !grp2) dec.wr_fifo = 1'b1;
        else                       dec.wr_dac  = 1'b1;
      end
    end
    if (rd) begin
      dec.rd_dio  = (addr == OFS_DIO);
      dec.rd_stat = (addr == OFS_CTLA);
      dec.rd_fclr = (addr == OFS_DATA);
    end
  end
endmodule

// File: rtl/aoc_irq_flags.sv
module aoc_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flag[g] <= 1'b0;
      else if (set_evt[g]) flag[g] <= 1'b1;
      else if (clr[g])     flag[g] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag[g] && !clr[g]) |=> flag[g]); // R4
    AST_FLAG_NOSET: assert property (@(posedge clk) disable iff (rst)
      (!flag[g] && !set_evt[g]) |=> !flag[g]); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (clr[g] && !set_evt[g]) |=> !flag[g]); // R5
  end
endmodule

// File: rtl/aoc_dio_port.sv
module aoc_dio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] wdata,
  input  logic         oe_lo,
  input  logic         oe_hi,
  output logic [W-1:0] dio_out,
  output logic [W-1:0] dio_oe
);
  localparam int HALF = W / 2;

  always_ff @(posedge clk) begin
    if (rst)     dio_out <= '0;
    else if (ld) dio_out <= wdata;
  end

  for (genvar g = 0; g < 2; g++) begin : g_nib
    assign dio_oe[g*HALF +: HALF] = {HALF{(g == 0) ? oe_lo : oe_hi}};
  end

  AST_OE_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    ($countones(dio_oe[HALF-1:0]) == 0) || ($countones(dio_oe[HALF-1:0]) == HALF)); // R7
endmodule

// File: rtl/aoc_regbank.sv
module aoc_regbank
  import aoc_regbank_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DIO_W-1:0]  dio_pin_in,
  output logic [DIO_W-1:0]  dio_out,
  output logic [DIO_W-1:0]  dio_oe,
  input  logic              fifo_half,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic              cal_sdo,
  input  logic              ext_evt1,
  input  logic              ext_evt2,
  input  logic              cnt_evt1,
  input  logic              cnt_evt2,
  input  logic              tc_evt,
  output logic [DATA_W-1:0] ctl_a_q,
  output logic [CTLB_W-1:0] ctl_b_q,
  output logic [NFLAG-1:0]  flag_q,
  output logic              dac_wr,
  output logic [CH_W-1:0]   dac_chan,
  output logic [DAC_W-1:0]  dac_data,
  output logic              fifo_wr,
  output logic              fifo_clr,
  output logic              sync_sdata,
  output logic              sync_strobe
);
  dec_t             dec;
  logic [NFLAG-1:0] set_evt;
  logic [DATA_W-1:0] status_w;

  aoc_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .grp2 (ctl_a_q[BIT_GRP2]),
    .dec  (dec)
  );

  always_comb begin
    set_evt         = '0;
    set_evt[FLG_TC] = tc_evt & ctl_a_q[BIT_TC_EN];
    set_evt[FLG_I1] = (ext_evt1 & ctl_a_q[BIT_EXT1_EN]) | (cnt_evt1 & ctl_a_q[BIT_CNT1_EN]);
    set_evt[FLG_I2] = (ext_evt2 & ctl_a_q[BIT_EXT2_EN]) | (cnt_evt2 & ctl_a_q[BIT_CNT2_EN]);
  end

  aoc_irq_flags #(.N(NFLAG)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_evt (set_evt),
    .clr     (dec.clr),
    .flag    (flag_q)
  );

  aoc_dio_port #(.W(DIO_W)) u_dio (
    .clk     (clk),
    .rst     (rst),
    .ld      (dec.ld_dio),
    .wdata   (bus_wdata[DIO_W-1:0]),
    .oe_lo   (ctl_b_q[BIT_OE_LO]),
    .oe_hi   (ctl_b_q[BIT_OE_HI]),
    .dio_out (dio_out),
    .dio_oe  (dio_oe)
  );

  always_comb begin
    status_w    = '0;
    status_w[6] = fifo_half;
    status_w[5] = fifo_empty;
    status_w[4] = fifo_full;
    status_w[3] = flag_q[FLG_I2];
    status_w[2] = flag_q[FLG_I1];
    status_w[1] = flag_q[FLG_TC];
    status_w[0] = cal_sdo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_a_q     <= '0;
      ctl_b_q     <= '0;
      sync_sdata  <= 1'b0;
      sync_strobe <= 1'b0;
      dac_wr      <= 1'b0;
      fifo_wr     <= 1'b0;
      fifo_clr    <= 1'b0;
      dac_chan    <= '0;
      dac_data    <= '0;
      bus_rdata   <= '0;
    end else begin
      if (dec.ld_ctla) ctl_a_q <= bus_wdata;
      if (dec.ld_ctlb) ctl_b_q <= bus_wdata[CTLB_W-1:0];
      if (dec.ld_sdat) sync_sdata <= bus_wdata[0];
      sync_strobe <= dec.stb_sync;
      dac_wr      <= dec.wr_dac;
      fifo_wr     <= dec.wr_fifo;
      fifo_clr    <= dec.rd_fclr;
      if (dec.wr_dac || dec.wr_fifo) begin
        dac_chan <= dec.ch;
        dac_data <= bus_wdata[DAC_W-1:0];
      end
      if (dec.rd_stat)     bus_rdata <= status_w;
      else if (dec.rd_dio) bus_rdata <= DATA_W'(dio_pin_in);
      else if (bus_rd)     bus_rdata <= '0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (ctl_a_q == '0 && ctl_b_q == '0 && !dac_wr && !fifo_wr)); // R1
  AST_CTLA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_CTLA) |=> (ctl_a_q == $past(bus_wdata))); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dac_wr && fifo_wr)); // R9
  AST_FIFO_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_DATA) |=> fifo_clr); // R10
  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
    dac_wr |-> (dac_chan < CH_W'(NUM_CH))); // R12
  AST_G2_KEEPS_DIO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctl_a_q[BIT_GRP2] && bus_addr == OFS_DIO) |=> $stable(dio_out)); // R6
endmodule

// File: tb/sim_aoc_regbank.sv
module sim_aoc_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  dio_pin_in = '0;
  logic [7:0]  dio_out, dio_oe;
  logic        fifo_half = 1'b0, fifo_empty = 1'b0, fifo_full = 1'b0, cal_sdo = 1'b0;
  logic        ext_evt1 = 1'b0, ext_evt2 = 1'b0, cnt_evt1 = 1'b0, cnt_evt2 = 1'b0, tc_evt = 1'b0;
  logic [15:0] ctl_a_q;
  logic [6:0]  ctl_b_q;
  logic [2:0]  flag_q;
  logic        dac_wr, fifo_wr, fifo_clr, sync_sdata, sync_strobe;
  logic [3:0]  dac_chan;
  logic [11:0] dac_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [16:0] exp_q[$];   // {is_fifo, chan[3:0], data[11:0]}

  always #2 clk = ~clk;

  aoc_regbank #(.NUM_CH(6)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic is_fifo, input logic [3:0] ch, input logic [11:0] d);
    exp_q.push_back({is_fifo, ch, d});
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (dac_wr || fifo_wr)) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R12 unexpected strobe actual=%0h expected=none",
                 {fifo_wr, dac_chan, dac_data});
      end else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        if ({fifo_wr, dac_chan, dac_data} !== e || (dac_wr === fifo_wr)) begin
          n_fail++;
          $display("FAIL R8/R9 strobe actual=%0h expected=%0h",
                   {fifo_wr, dac_chan, dac_data}, e);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl_a", ctl_a_q, 0);
    chk("R1 ctl_b", ctl_b_q, 0);
    chk("R1 flags", flag_q, 0);
    chk("R1 dio_oe", dio_oe, 0);
    chk("R1 strobes", {dac_wr, fifo_wr, fifo_clr, sync_strobe}, 0);

    // R3 status layout
    fifo_half = 1'b1; fifo_full = 1'b1; cal_sdo = 1'b1;
    rd(5'h0a, r);
    chk("R3 status", r, 16'h0051);

    // R6 / R7 bank-1 writes
    wr(5'h04, 16'h0004);
    chk("R7 low nibble oe", dio_oe, 8'h0f);
    wr(5'h00, 16'h00a5);
    chk("R6 dio latch", dio_out, 8'ha5);
    wr(5'h04, 16'h000c);
    chk("R7 both nibbles oe", dio_oe, 8'hff);
    chk("R6 ctl_b load", ctl_b_q, 7'h0c);
    dio_pin_in = 8'h3c;
    rd(5'h00, r);
    chk("R7 pin readback", r, 16'h003c);

    // R4 disabled event sets nothing
    @(negedge clk); ext_evt1 = 1'b1; tc_evt = 1'b1;
    @(negedge clk); ext_evt1 = 1'b0; tc_evt = 1'b0;
    chk("R4 disabled events", flag_q, 3'b000);

    // R2 / R4 enable and set
    wr(5'h0a, 16'hf800);
    chk("R2 ctl_a load", ctl_a_q, 16'hf800);
    @(negedge clk); ext_evt1 = 1'b1;
    @(negedge clk); ext_evt1 = 1'b0;
    chk("R4 INT1 set", flag_q, 3'b010);
    @(negedge clk); cnt_evt2 = 1'b1;
    @(negedge clk); cnt_evt2 = 1'b0;
    @(negedge clk); tc_evt = 1'b1;
    @(negedge clk); tc_evt = 1'b0;
    repeat (5) @(negedge clk);
    chk("R4 sticky all", flag_q, 3'b111);
    rd(5'h0a, r);
    chk("R3 status flags", r, 16'h005f);

    // R5 bank-2 clears, R6 no side effects
    wr(5'h0a, 16'hf880);
    chk("R2 bank select", ctl_a_q[7], 1'b1);
    wr(5'h02, 16'h0000);
    chk("R5 clear INT1", flag_q, 3'b101);
    wr(5'h00, 16'h00ff);
    chk("R5 clear TC", flag_q, 3'b100);
    chk("R6 dio kept in bank 2", dio_out, 8'ha5);
    wr(5'h04, 16'h0000);
    chk("R5 clear INT2", flag_q, 3'b000);
    chk("R6 ctl_b kept in bank 2", ctl_b_q, 7'h0c);

    // R9 / R8 / R12 converter writes in bank 2
    push(1'b0, 4'd0, 12'h800);
    wr(5'h0c, 16'h0800);
    chk("R9 ch0 dac_wr", {dac_wr, fifo_wr}, 2'b10);
    push(1'b0, 4'd1, 12'hfff);
    wr(5'h0e, 16'hffff);
    push(1'b0, 4'd5, 12'h7ff);
    wr(5'h16, 16'h07ff);
    wr(5'h18, 16'h0123);
    chk("R12 above last channel", {dac_wr, fifo_wr}, 2'b00);

    // R11 sync line
    wr(5'h06, 16'h0001);
    chk("R11 sdata", sync_sdata, 1'b1);
    wr(5'h07, 16'h0000);
    chk("R11 strobe high", sync_strobe, 1'b1);
    @(negedge clk);
    chk("R11 strobe one cycle", sync_strobe, 1'b0);

    // bank 1: FIFO push at shared offset, channel 2 still reachable
    wr(5'h0a, 16'h0003);
    chk("R2 reload", ctl_a_q, 16'h0003);
    push(1'b1, 4'd0, 12'h123);
    wr(5'h0c, 16'h0123);
    chk("R9 fifo_wr in bank 1", {dac_wr, fifo_wr}, 2'b01);
    push(1'b0, 4'd2, 12'h456);
    wr(5'h10, 16'h0456);
    chk("R8 ch2 in bank 1", dac_chan, 4'd2);

    // R10 FIFO clear on read
    rd(5'h0c, r);
    chk("R10 fifo_clr pulse", fifo_clr, 1'b1);
    @(negedge clk);
    chk("R10 fifo_clr one cycle", fifo_clr, 1'b0);

    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule